// File: doc/BRIEF.md
# Destination Address Hash Filter

This block makes the receive-side accept/reject decision for an Ethernet frame from its 48-bit destination address alone. It checks the address against one programmed station address and against a 64-bit hash table. The hash table is indexed by a 6-bit XOR fold of the address. Broadcast, copy-all, unicast-hash and multicast-hash controls then shape the result. The receive path presents the address together with a one-cycle valid strobe. One clock later the block returns an accept pulse and a code that names the rule that matched. Frame storage stays with the receive path.

Bit `da[0]` is the least significant bit of the first address byte on the wire, and it is the group (multicast) indicator. Software sets up the block through a plain write port: a 3-bit select, a 32-bit data word and an enable. Both the station address and the hash table are split across 32-bit words.

Top module: `da_hash_filter`

## Requirements
- R1: After reset, `accept` is 0 and `reason` is 0, and all registers are cleared, so the broadcast control is off and a broadcast address is accepted with reason 2.
- R2: `accept` and `reason` change in the cycle after a clock edge that samples `da_valid` high, and they hold for exactly one cycle. In every other cycle `accept` is 0 and `reason` is 0.
- R3: The hash index bit j (j = 0..5) is the XOR of `da[j]`, `da[j+6]`, `da[j+12]` and so on up to `da[j+42]`. The table bit at that index is the one consulted.
- R4: With the multicast-hash enable set, an address with `da[0]`=1 whose table bit is set is accepted with reason 3. A table of all ones with this enable set accepts every multicast address.
- R5: With the unicast-hash enable set, an address with `da[0]`=0 whose table bit is set is accepted with reason 4. A hash hit whose `da[0]` does not match the enable that is set is not accepted on that account.
- R6: Select 2 writes table bits 31:0 and select 3 writes table bits 63:32. Table bit n is `wr_data[n]` and `wr_data[n-32]` respectively.
- R7: Select 0 writes station bytes 0..3, with byte 0 in `wr_data[7:0]`, so that `da[31:0]` is compared with `wr_data[31:0]`. Select 1 writes bytes 4..5 from `wr_data[15:0]`, compared with `da[47:32]`, and bits 31:16 are ignored. An exact match is accepted with reason 1.
- R8: The all-ones address is accepted with reason 2 when the no-broadcast control is clear. When that control is set, the all-ones address is rejected, whatever the hash or station match, unless copy-all is on; in that case it is accepted with reason 5.
- R9: With copy-all set, every address is accepted. Reason 5 is reported when no higher rule matches.
- R10: For a non-broadcast address the reason follows this priority: station match (1), then multicast hash (3), then unicast hash (4), then copy-all (5). Reason 0 means rejected.
- R11: Select 4 writes the control word: bit 0 copy-all, bit 1 no-broadcast, bit 2 unicast-hash enable, bit 3 multicast-hash enable. Writes with select 5, 6 or 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0,1 station; 2,3 table; 4 control) |
| wr_data | input | 32 | Register write data |
| da_valid | input | 1 | Destination address valid strobe |
| da | input | 48 | Destination address, `da[0]` first bit received |
| accept | output | 1 | One-cycle accept pulse |
| reason | output | 3 | Match code (0 none, 1 station, 2 broadcast, 3 mc hash, 4 uc hash, 5 copy-all) |

## Verification
A corrupted table word, station word or control bit shows up as a wrong `reason` on the very next address whose fold or byte lane lands on the damaged bit. The damage is visible one clock after that strobe. To expose every one of the 64 table bits, the bench steers addresses onto each hash index in turn with a one-hot table. It does this for both `da[0]` values and with the wrong enable as well. A swept set of control words combined with broadcast, station and scattered addresses exposes errors in priority and in byte placement.

// File: rtl/da_hash_filter.sv
module da_hash_filter #(
  parameter int DA_W   = 48,
  parameter int IDX_W  = 6,
  parameter int WORD_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              da_valid,
  input  logic [DA_W-1:0]   da,
  output logic              accept,
  output logic [2:0]        reason
);
  localparam int TBL_W = 1 << IDX_W;
  localparam int HI_W  = DA_W - WORD_W;

  localparam logic [2:0] RSN_NONE = 3'd0;
  localparam logic [2:0] RSN_STN  = 3'd1;
  localparam logic [2:0] RSN_BC   = 3'd2;
  localparam logic [2:0] RSN_MC   = 3'd3;
  localparam logic [2:0] RSN_UC   = 3'd4;
  localparam logic [2:0] RSN_ALL  = 3'd5;

  logic [WORD_W-1:0] stn_lo;
  logic [HI_W-1:0]   stn_hi;
  logic [TBL_W-1:0]  tbl;
  logic              copy_all, no_bc, uc_en, mc_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stn_lo   <= '0;
      stn_hi   <= '0;
      tbl      <= '0;
      copy_all <= 1'b0;
      no_bc    <= 1'b0;
      uc_en    <= 1'b0;
      mc_en    <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: stn_lo <= wr_data;
        3'd1: stn_hi <= wr_data[HI_W-1:0];
        3'd2: tbl[WORD_W-1:0] <= wr_data;
        3'd3: tbl[2*WORD_W-1:WORD_W] <= wr_data;
        3'd4: {mc_en, uc_en, no_bc, copy_all} <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  logic [IDX_W-1:0] idx;
  always_comb begin
    idx = '0;
    for (int j = 0; j < IDX_W; j++)
      for (int k = j; k < DA_W; k += IDX_W)
        idx[j] = idx[j] ^ da[k];
  end

  wire tbl_hit = tbl[idx];
  wire is_bc   = &da;
  wire stn_hit = (da == {stn_hi, stn_lo});
  wire mc_hit  = mc_en & da[0] & tbl_hit;
  wire uc_hit  = uc_en & ~da[0] & tbl_hit;

  logic [2:0] nxt;
  always_comb begin
    if (is_bc)        nxt = !no_bc ? RSN_BC : (copy_all ? RSN_ALL : RSN_NONE);
    else if (stn_hit) nxt = RSN_STN;
    else if (mc_hit)  nxt = RSN_MC;
    else if (uc_hit)  nxt = RSN_UC;
    else if (copy_all) nxt = RSN_ALL;
    else              nxt = RSN_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept <= 1'b0;
      reason <= RSN_NONE;
    end else begin
      accept <= da_valid && (nxt != RSN_NONE);
      reason <= da_valid ? nxt : RSN_NONE;
    end
  end

  // R2
  p_pulse_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(da_valid));
  p_quiet_reason_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> reason == RSN_NONE);
  // R9
  p_copy_all_accepts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(da_valid) && $past(copy_all)) |-> accept);
  // R8
  p_no_bcast_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(da_valid && is_bc && no_bc && !copy_all) |-> !accept);
  // R4
  p_mc_needs_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reason == RSN_MC) |-> $past(da[0] && mc_en));
  // R5
  p_uc_needs_individual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reason == RSN_UC) |-> $past(!da[0] && uc_en));
endmodule

// File: tb/da_hash_filter_test.sv
module da_hash_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic        accept;
  logic [2:0]  reason;

  da_hash_filter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .da_valid(da_valid), .da(da), .accept(accept), .reason(reason)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_lo = '0;
  logic [15:0] m_hi = '0;
  logic [63:0] m_tbl = '0;
  logic [3:0]  m_cfg = '0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  function automatic logic [47:0] next_addr();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed[63:16];
  endfunction

  function automatic logic [5:0] fold_idx(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int i = 0; i < 48; i++) r[i % 6] = r[i % 6] ^ a[i];
    return r;
  endfunction

  function automatic logic [2:0] model(input logic [47:0] a);
    logic hit = m_tbl[fold_idx(a)];
    if (a == {48{1'b1}}) return !m_cfg[1] ? 3'd2 : (m_cfg[0] ? 3'd5 : 3'd0);
    if (a == {m_hi, m_lo}) return 3'd1;
    if (m_cfg[3] && a[0] && hit) return 3'd3;
    if (m_cfg[2] && !a[0] && hit) return 3'd4;
    if (m_cfg[0]) return 3'd5;
    return 3'd0;
  endfunction

  function automatic string rtag(input logic [2:0] r);
    case (r)
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      3'd0: m_lo = d;
      3'd1: m_hi = d[15:0];
      3'd2: m_tbl[31:0] = d;
      3'd3: m_tbl[63:32] = d;
      3'd4: m_cfg = d[3:0];
      default: ;
    endcase
  endtask

  task automatic apply(input logic [47:0] a, input string tag);
    logic [2:0] e = model(a);
    @(negedge clk);
    da = a; da_valid = 1'b1;
    @(negedge clk);
    da_valid = 1'b0; da = '0;
    check(accept == (e != 3'd0) && reason == e, tag, {accept, reason}, {(e != 3'd0), e});
    @(negedge clk);
    check(!accept && reason == 3'd0, "R2", {accept, reason}, 0);
  endtask

  task automatic expect_hit(input logic [47:0] a, input logic [2:0] e, input string tag);
    check(model(a) == e, {tag, " model"}, model(a), e);
    apply(a, tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [47:0] stn, a, b;
    logic [5:0]  d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!accept && reason == 3'd0, "R1", {accept, reason}, 0);
    expect_hit({48{1'b1}}, 3'd2, "R1");

    // control word sweep with fixed station and table
    wr(3'd0, 32'h89AB_CDEF);
    wr(3'd1, 32'hFFFF_4567);
    stn = 48'h4567_89AB_CDEF;
    wr(3'd2, 32'h0F0F_5A5A);
    wr(3'd3, 32'hF0F0_A5A5);
    for (int c = 0; c < 16; c++) begin
      wr(3'd4, c);
      apply(stn, "R10");
      apply(stn ^ 48'h1, rtag(model(stn ^ 48'h1)));
      apply(stn ^ 48'h0100_0000_0000, "R7");
      apply({48{1'b1}}, "R8");
      for (int k = 0; k < 10; k++) begin
        a = next_addr();
        apply(a, rtag(model(a)));
      end
    end

    // walk every hash index for both address kinds
    for (int t = 0; t < 64; t++) begin
      for (int g = 0; g < 2; g++) begin
        a = next_addr();
        a[0] = g[0];
        d = fold_idx(a) ^ t[5:0];
        for (int j = 0; j < 6; j++) if (d[j]) a[6+j] = ~a[6+j];
        wr(3'd2, t < 32 ? (32'd1 << t) : 32'd0);
        wr(3'd3, t >= 32 ? (32'd1 << (t - 32)) : 32'd0);
        wr(3'd4, g ? 32'd8 : 32'd4);
        expect_hit(a, g ? 3'd3 : 3'd4, t >= 32 ? "R6" : "R3");
        b = a; b[6] = ~b[6];
        expect_hit(b, 3'd0, "R3");
        wr(3'd4, g ? 32'd4 : 32'd8);
        expect_hit(a, 3'd0, "R5");
      end
    end

    // all-ones table accepts every multicast address
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'd8);
    for (int k = 0; k < 16; k++) begin
      a = next_addr();
      a[0] = 1'b1;
      if (a != {48{1'b1}}) expect_hit(a, 3'd3, "R4");
      a[0] = 1'b0;
      expect_hit(a, 3'd0, "R4");
    end

    // broadcast blocked despite hash hit, rescued by copy-all
    wr(3'd4, 32'd10);
    expect_hit({48{1'b1}}, 3'd0, "R8");
    wr(3'd4, 32'd11);
    expect_hit({48{1'b1}}, 3'd5, "R8");

    // reserved selects leave everything unchanged
    wr(3'd4, 32'd0);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    a = next_addr();
    if (a == stn) a[5] = ~a[5];
    expect_hit(a, 3'd0, "R11");
    expect_hit(stn, 3'd1, "R11");
    expect_hit({48{1'b1}}, 3'd2, "R11");

    finish_run();
  end
endmodule